// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a DDR SDRAM refreshed on behalf of a memory controller. A free-running interval counter creates one refresh credit every refresh period. The command scheduler may hold credits back while it has useful traffic, and signals quiet windows through `ref_ok_i`. When the credit count reaches its ceiling, the block raises an urgent flag, which blocks new row activations. It then forces the next refresh whatever the scheduler wants.

Each refresh is a fixed sequence: a precharge-all command, a row-precharge wait, the auto-refresh command, and a refresh-cycle wait. The bus is marked busy for the whole sequence.

On request the block also puts the device into self-refresh. It precharges all banks, waits the row-precharge time and then drives the clock enable low. While the clock enable is low, the interval counter is frozen. When the request drops, the clock enable returns high and all owed credits are dropped. Two separate gates then open in turn: a short one for non-read commands and a long one for reads.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, `cke_o` is 1, `read_ok_o` and `nonread_ok_o` are 1, and `busy_o`, `urgent_o`, `pre_all_o`, `ref_o` and `owed_o` are 0.
- R2: `owed_o` rises by one after every REFI_CYCLES clocks in which the clock enable is high; the first increment comes REFI_CYCLES clocks after reset. It falls by one for each refresh command and saturates at MAX_OWED (a credit arriving at the ceiling is lost).
- R3: A refresh sequence runs as follows:
  - `pre_all_o` is high for one cycle.
  - TRP_CYC quiet cycles follow.
  - `ref_o` is high for one cycle.
  - TRFC_CYC quiet cycles follow.
  
  `busy_o` is high from the precharge-all cycle to the last wait cycle, a total of TRP_CYC+TRFC_CYC+2 cycles.
- R4: If owed credits are below MAX_OWED, a sequence starts only from idle, and only when `ref_ok_i` is high and `owed_o` is non-zero. With `ref_ok_i` low, credits accumulate and no precharge-all is issued.
- R5: `urgent_o` is high exactly when `owed_o` equals MAX_OWED. From idle, an urgent state starts a refresh sequence on the next cycle, regardless of `ref_ok_i` and ahead of a self-refresh request.
- R6: The idle priority is urgent refresh, then self-refresh, then normal refresh. A self-refresh request taken from idle gives the following:
  - one precharge-all cycle;
  - TRP_CYC quiet cycles;
  - `cke_o` low for as long as `sr_req_i` stays high.
  
  While `cke_o` is low, no credit is added.
- R7: The cycle after `sr_req_i` is seen low in self-refresh, `cke_o` is high again. `nonread_ok_o` returns high TXSNR_CYC cycles later and `read_ok_o` TXSRD_CYC cycles later. Both are low while `cke_o` is low.
- R8: On leaving self-refresh, `owed_o` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok_i | input | 1 | Scheduler allows a postponed refresh now |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| pre_all_o | output | 1 | Precharge-all command pulse |
| ref_o | output | 1 | Auto-refresh command pulse |
| cke_o | output | 1 | Clock enable to the device |
| busy_o | output | 1 | Block owns the command bus |
| urgent_o | output | 1 | Credit ceiling reached, block activates |
| owed_o | output | $clog2(MAX_OWED+1) | Refresh credits owed |
| nonread_ok_o | output | 1 | Non-read commands permitted |
| read_ok_o | output | 1 | Read commands permitted |

## Verification
The bench starves `ref_ok_i` until the credit count reaches its ceiling. A design that waited for permission there would leave `urgent_o` stuck and never issue the forced precharge-all. The bench also parks the device in self-refresh for longer than a refresh period with credits already owed. A counter that kept running would raise `owed_o` during the sleep, and a missing clear would carry stale credits past wake-up. It then counts the exact cycles from the request drop to each wake-up gate; swapped or shared delays show up as a read gate opening with the non-read gate. A random permission pattern then runs against the cycle model, which catches off-by-one waits in the precharge and refresh gaps and a credit lost when a tick and a refresh land together.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_RP, ST_REF, ST_RFC,
    ST_SPRE, ST_SRP, ST_SR, ST_XS
  } rfsh_state_t;

  // Next credit count: clear wins, then add/remove with clamping to [0, lim].
  function automatic int owed_step(int cur, logic inc, logic dec, logic clr, int lim);
    int n;
    if (clr) return 0;
    n = cur + int'(inc) - int'(dec);
    if (n > lim) n = lim;
    if (n < 0) n = 0;
    return n;
  endfunction
endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int REFI_CYCLES = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CNT_W = (REFI_CYCLES > 1) ? $clog2(REFI_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REFI_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick_o = !hold_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!hold_i) cnt <= tick_o ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit
  import rfsh_pkg::*;
#(
  parameter int MAX_OWED = 8,
  localparam int OWED_W = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              clr_i,
  output logic [OWED_W-1:0] owed_o,
  output logic              urgent_o,
  output logic              nz_o
);
  assign urgent_o = (owed_o == OWED_W'(MAX_OWED));
  assign nz_o     = (owed_o != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) owed_o <= '0;
    else owed_o <= OWED_W'(owed_step(int'(owed_o), inc_i, dec_i, clr_i, MAX_OWED));
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int TRP_CYC   = 1,
  parameter int TRFC_CYC  = 4,
  parameter int TXSNR_CYC = 4,
  parameter int TXSRD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok_i,
  input  logic sr_req_i,
  input  logic urgent_i,
  input  logic owed_nz_i,
  output logic pre_all_o,
  output logic ref_o,
  output logic cke_o,
  output logic busy_o,
  output logic nonread_ok_o,
  output logic read_ok_o,
  output logic idle_o,
  output logic hold_o,
  output logic wake_o
);
  localparam int TMAX  = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int XS_W  = $clog2(TXSRD_CYC + 1);
  localparam int SP_W  = $clog2(TRP_CYC + 3);
  localparam logic [XS_W-1:0] XSNR_L = XS_W'(TXSNR_CYC);
  localparam logic [XS_W-1:0] XSRD_L = XS_W'(TXSRD_CYC);

  rfsh_state_t st, st_n;
  logic [TMR_W-1:0] tmr;
  logic [XS_W-1:0]  xcnt;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: begin
        if (urgent_i)                    st_n = ST_PRE;
        else if (sr_req_i)               st_n = ST_SPRE;
        else if (ref_ok_i && owed_nz_i)  st_n = ST_PRE;
      end
      ST_PRE:  st_n = ST_RP;
      ST_RP:   if (tmr == '0) st_n = ST_REF;
      ST_REF:  st_n = ST_RFC;
      ST_RFC:  if (tmr == '0) st_n = ST_IDLE;
      ST_SPRE: st_n = ST_SRP;
      ST_SRP:  if (tmr == '0) st_n = ST_SR;
      ST_SR:   if (!sr_req_i) st_n = ST_XS;
      ST_XS:   if (xcnt == XSRD_L) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tmr  <= '0;
      xcnt <= '0;
    end else begin
      st <= st_n;
      if (st == ST_PRE || st == ST_SPRE) tmr <= TMR_W'(TRP_CYC - 1);
      else if (st == ST_REF)             tmr <= TMR_W'(TRFC_CYC - 1);
      else if (tmr != '0)                tmr <= tmr - 1'b1;
      xcnt <= (st == ST_XS) ? xcnt + 1'b1 : '0;
    end
  end

  assign pre_all_o    = (st == ST_PRE) || (st == ST_SPRE);
  assign ref_o        = (st == ST_REF);
  assign cke_o        = (st != ST_SR);
  assign busy_o       = (st != ST_IDLE) && (st != ST_XS);
  assign nonread_ok_o = (st != ST_SR) && !((st == ST_XS) && (xcnt < XSNR_L));
  assign read_ok_o    = (st != ST_SR) && !((st == ST_XS) && (xcnt < XSRD_L));
  assign idle_o       = (st == ST_IDLE);
  assign hold_o       = (st == ST_SR);
  assign wake_o       = (st == ST_SR) && !sr_req_i;

  // Cycles since the last precharge-all, used only by the spacing check.
  logic [SP_W-1:0] since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) since_pre <= '0;
    else if (pre_all_o) since_pre <= SP_W'(1);
    else if (since_pre != '1) since_pre <= since_pre + 1'b1;
  end

  // R3: refresh command lands exactly TRP_CYC quiet cycles after precharge-all
  a_r3_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ref_o |-> (since_pre == SP_W'(TRP_CYC + 1)));

  // R7: the read gate never opens before the non-read gate
  a_r7_read_after_nonread: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok_o |-> nonread_ok_o);
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int REFI_CYCLES = 390,
  parameter int MAX_OWED    = 8,
  parameter int TRP_CYC     = 1,
  parameter int TRFC_CYC    = 4,
  parameter int TXSNR_CYC   = 4,
  parameter int TXSRD_CYC   = 200,
  localparam int OWED_W     = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_ok_i,
  input  logic              sr_req_i,
  output logic              pre_all_o,
  output logic              ref_o,
  output logic              cke_o,
  output logic              busy_o,
  output logic              urgent_o,
  output logic [OWED_W-1:0] owed_o,
  output logic              nonread_ok_o,
  output logic              read_ok_o
);
  logic tick, hold, wake, idle, owed_nz;

  rfsh_interval #(.REFI_CYCLES(REFI_CYCLES)) u_interval (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .tick_o(tick));

  rfsh_credit #(.MAX_OWED(MAX_OWED)) u_credit (
    .clk(clk), .rst_n(rst_n), .inc_i(tick), .dec_i(ref_o), .clr_i(wake),
    .owed_o(owed_o), .urgent_o(urgent_o), .nz_o(owed_nz));

  rfsh_seq #(
    .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .TXSNR_CYC(TXSNR_CYC), .TXSRD_CYC(TXSRD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_ok_i(ref_ok_i), .sr_req_i(sr_req_i),
    .urgent_i(urgent_o), .owed_nz_i(owed_nz),
    .pre_all_o(pre_all_o), .ref_o(ref_o), .cke_o(cke_o), .busy_o(busy_o),
    .nonread_ok_o(nonread_ok_o), .read_ok_o(read_ok_o),
    .idle_o(idle), .hold_o(hold), .wake_o(wake));

  // R6: no credit is generated while the clock enable is low
  a_r6_no_tick_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> !tick);

  // R8: credits are gone when the clock enable comes back
  a_r8_clear_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (owed_o == '0));

  // R5: urgent state in idle forces a precharge-all next cycle
  a_r5_urgent_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_o && idle) |=> pre_all_o);

  // R2: every refresh command consumes one credit
  a_r2_ref_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    ref_o |=> (int'(owed_o) == int'($past(owed_o)) - 1 + ($past(tick) ? 1 : 0)));
endmodule

// File: tb/test_rfsh_sched.sv
`timescale 1ns/1ps
module test_rfsh_sched;
  localparam int REFI  = 40;
  localparam int MAXO  = 8;
  localparam int TRP   = 1;
  localparam int TRFC  = 4;
  localparam int TXSNR = 4;
  localparam int TXSRD = 200;
  localparam int OW    = $clog2(MAXO + 1);

  logic clk = 0, rst_n = 0, ref_ok = 0, sr_req = 0;
  logic pre_all, ref_cmd, cke, busy, urgent, nonread_ok, read_ok;
  logic [OW-1:0] owed;

  always #10 clk = ~clk;

  rfsh_sched #(.REFI_CYCLES(REFI), .MAX_OWED(MAXO), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
               .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD)) i_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .ref_ok_i(ref_ok), .sr_req_i(sr_req),
    .pre_all_o(pre_all), .ref_o(ref_cmd), .cke_o(cke), .busy_o(busy),
    .urgent_o(urgent), .owed_o(owed), .nonread_ok_o(nonread_ok), .read_ok_o(read_ok));

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Behavioural reference: mode 0 idle, 1 refresh, 2 entering sleep, 3 asleep, 4 waking.
  int m_mode = 0, m_age = 0, m_owed = 0, m_icnt = 0;
  always @(posedge clk) begin
    int tk, dc, nm, na, no;
    bit cl;
    if (!rst_n) begin
      m_mode = 0; m_age = 0; m_owed = 0; m_icnt = 0;
    end else begin
      tk = (m_mode != 3 && m_icnt == REFI - 1) ? 1 : 0;
      dc = (m_mode == 1 && m_age == TRP + 1) ? 1 : 0;
      cl = (m_mode == 3 && !sr_req);
      nm = m_mode; na = m_age + 1;
      case (m_mode)
        0: begin
          na = 0;
          if (m_owed == MAXO) nm = 1;
          else if (sr_req) nm = 2;
          else if (ref_ok && m_owed > 0) nm = 1;
        end
        1: if (m_age == TRP + TRFC + 1) begin nm = 0; na = 0; end
        2: if (m_age == TRP) begin nm = 3; na = 0; end
        3: begin na = 0; if (!sr_req) nm = 4; end
        default: if (m_age == TXSRD) begin nm = 0; na = 0; end
      endcase
      no = cl ? 0 : m_owed + tk - dc;
      if (no > MAXO) no = MAXO;
      if (m_mode != 3) m_icnt = (tk != 0) ? 0 : m_icnt + 1;
      m_owed = no; m_mode = nm; m_age = na;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int e_pre, e_ref, e_busy, e_cke, e_nr, e_rd;
      e_pre  = ((m_mode == 1 || m_mode == 2) && m_age == 0) ? 1 : 0;
      e_ref  = (m_mode == 1 && m_age == TRP + 1) ? 1 : 0;
      e_busy = (m_mode >= 1 && m_mode <= 3) ? 1 : 0;
      e_cke  = (m_mode != 3) ? 1 : 0;
      e_nr   = (m_mode != 3 && !(m_mode == 4 && m_age < TXSNR)) ? 1 : 0;
      e_rd   = (m_mode != 3 && !(m_mode == 4 && m_age < TXSRD)) ? 1 : 0;
      chk(int'(pre_all) == e_pre,  "R3", "pre_all", int'(pre_all), e_pre);
      chk(int'(ref_cmd) == e_ref,  "R3", "ref", int'(ref_cmd), e_ref);
      chk(int'(busy) == e_busy,    "R3", "busy", int'(busy), e_busy);
      chk(int'(owed) == m_owed,    "R2", "owed", int'(owed), m_owed);
      chk(int'(urgent) == ((m_owed == MAXO) ? 1 : 0), "R5", "urgent", int'(urgent), (m_owed == MAXO) ? 1 : 0);
      chk(int'(cke) == e_cke,      "R6", "cke", int'(cke), e_cke);
      chk(int'(nonread_ok) == e_nr, "R7", "nonread_ok", int'(nonread_ok), e_nr);
      chk(int'(read_ok) == e_rd,   "R7", "read_ok", int'(read_ok), e_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    int n, pre_seen;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cke == 1 && read_ok == 1 && nonread_ok == 1, "R1", "enables", int'({cke, nonread_ok, read_ok}), 7);
    chk(busy == 0 && urgent == 0 && pre_all == 0 && ref_cmd == 0 && owed == 0, "R1", "idle outputs",
        int'({busy, urgent, pre_all, ref_cmd}) + int'(owed), 0);
    cmp_on = 1;

    // Normal refresh with permission granted
    ref_ok = 1;
    repeat (200) @(negedge clk);

    // R4: starve permission, no precharge until the ceiling (R5)
    ref_ok = 0; pre_seen = 0; n = 0;
    while (!urgent && n < 1000) begin
      @(negedge clk); n++;
      if (pre_all && !urgent) pre_seen++;
    end
    chk(pre_seen == 0, "R4", "precharge while postponed", pre_seen, 0);
    chk(int'(owed) == MAXO, "R5", "owed at urgent", int'(owed), MAXO);
    @(negedge clk);
    chk(pre_all == 1, "R5", "forced precharge", int'(pre_all), 1);
    repeat (60) @(negedge clk);

    // Drain, then build three credits before sleeping
    ref_ok = 1;
    while (owed != 0) @(negedge clk);
    ref_ok = 0;
    while (int'(owed) != 3) @(negedge clk);
    sr_req = 1;
    repeat (300) @(negedge clk);
    chk(cke == 0, "R6", "cke in sleep", int'(cke), 0);
    chk(int'(owed) == 3, "R6", "credits frozen in sleep", int'(owed), 3);
    sr_req = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!cke && n < 10);
    chk(n == 1, "R7", "cycles to cke high", n, 1);
    chk(int'(owed) == 0, "R8", "credits cleared on wake", int'(owed), 0);
    while (!nonread_ok && n < 1000) begin @(negedge clk); n++; end
    chk(n == TXSNR + 1, "R7", "cycles to non-read gate", n, TXSNR + 1);
    while (!read_ok && n < 1000) begin @(negedge clk); n++; end
    chk(n == TXSRD + 1, "R7", "cycles to read gate", n, TXSRD + 1);

    // Random permission pattern with periodic sleep requests
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ref_ok = lfsr[0] & lfsr[3];
      sr_req = ((i % 900) > 820);
      @(negedge clk);
    end
    sr_req = 0; ref_ok = 0;
    repeat (250) @(negedge clk);
    finish_run();
  end
endmodule